// File: doc/BRIEF.md
# Block-Counted Byte Transfer Sequencer

This block carries the data phase of a card data command between a byte-wide card data port and a 16-bit word FIFO. In the receive direction it gathers card bytes in pairs, the first byte in the low half of a word and the second in the high half, and pushes each word into the FIFO. In the transmit direction it takes the word at the FIFO head and sends its low byte, then its high byte, and then pops it. At most one byte crosses the card port per clock, and only on a valid/ready handshake.

Two counters keep track of the transfer. The byte counter holds the bytes left in the current block. The block counter holds the blocks left in the transfer. Software programs the block length and the block count through a small write port, and the live counters are always visible on outputs. When a block has an odd length, its last byte goes out as a half-filled word. When the last byte of the last block moves, the sequencer goes idle and gives a one-cycle done pulse. In receive, a new word is not started while the FIFO holds more words than a programmable almost-full level. Dropping the controller enable, or pulsing soft reset, aborts the transfer and clears both counters.

Top module: `xfer_seq`

## Requirements
- R1: After the synchronous reset, both counters read zero, no transfer is active, and card_rx_ready, card_tx_valid, fifo_wr_en, fifo_rd_en and xfer_done are all low.
- R2: A write with cfg_sel=0 loads the block length and the byte counter with cfg_wdata[10:0]+1. The range is 1 to 2048 bytes.
- R3: A write with cfg_sel=1 loads the block count and the block counter with cfg_wdata[10:0]+1. It also reloads the byte counter from the block length. This holds during a transfer as well.
- R4: In receive, the first byte of each pair lands in fifo_wdata[7:0] and the second in fifo_wdata[15:8]. When the block's last byte is the first of a pair, the word is pushed with bits [15:8] zero.
- R5: In receive, no new word is started while fifo_level > af_level, nor in the cycle in which a push is still pending. The second byte of a word that has already started is always taken.
- R6: In transmit, the low byte of the head word is sent first and then the high byte, followed by a pop. If the low byte ends the block, the word is popped without sending its high byte.
- R7: In transmit, card_tx_valid stays low while the FIFO is empty, and the counters do not move.
- R8: A byte moves only on a handshake (valid and ready both high), and at most one byte moves per clock. With no handshake, the counters hold.
- R9: When the byte counter reaches zero, it reloads from the block length and the block counter decrements.
- R10: When the last byte of the last block moves, the block counter reloads from the block count and the transfer goes inactive. xfer_done is then high for exactly one cycle.
- R11: bytes_left and blocks_left show the live remaining counts, not the programmed values.
- R12: While ctl_en is low, or in a cycle with soft_rst high, the transfer aborts and both counters clear. Configuration writes are ignored while ctl_en is low.
- R13: xfer_start is ignored while a transfer is active or while either counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; low aborts and clears |
| soft_rst | input | 1 | One-cycle software reset pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects block length, 1 selects block count |
| cfg_wdata | input | 11 | Written value minus one |
| xfer_start | input | 1 | Start pulse for a data transfer |
| xfer_rx | input | 1 | Direction at start: 1 receive from card, 0 transmit to card |
| af_level | input | 5 | Receive almost-full level in words |
| bytes_left | output | 12 | Live byte counter |
| blocks_left | output | 12 | Live block counter |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse at transfer end |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_data | input | 8 | Received byte |
| card_rx_ready | output | 1 | Sequencer accepts the received byte |
| card_tx_valid | output | 1 | Sequencer offers a byte to send |
| card_tx_data | output | 8 | Byte to send |
| card_tx_ready | input | 1 | Card accepts the byte |
| fifo_level | input | 6 | Words held in the FIFO; updates the cycle after a push or pop strobe |
| fifo_rdata | input | 16 | Word at the FIFO head |
| fifo_wr_en | output | 1 | Push strobe |
| fifo_wdata | output | 16 | Word to push |
| fifo_rd_en | output | 1 | Pop strobe |

## Verification
The hardest states to reach from the ports are the mid-transfer ones: a block boundary reached with blocks still left, a receive held at the almost-full level, and a count write landing while the byte counter sits partway through a block. The stimulus reaches them by programming a zero or small almost-full level and withholding FIFO drain. The receive then parks after a known number of bytes, and the counters are read back at that point before the transfer is aborted through the enable. The transmit stall is reached by starting with an empty FIFO and holding the card's ready low after the first word arrives.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    SEL_LEN = 1'b0,
    SEL_CNT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/xfer_seq_count.sv
module xfer_seq_count #(
  parameter int LEN_W = 11,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             wr_len,
  input  logic             wr_cnt,
  input  logic [LEN_W-1:0] wval,
  input  logic             step,
  output logic [CNT_W-1:0] bytes_q,
  output logic [CNT_W-1:0] blocks_q,
  output logic             last_byte,
  output logic             xfer_end
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] nblk_q;
  logic [CNT_W-1:0] wval_p1;

  assign wval_p1   = CNT_W'(wval) + ONE;
  assign last_byte = (bytes_q == ONE);
  assign xfer_end  = step && last_byte && (blocks_q == ONE);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      len_q    <= '0;
      nblk_q   <= '0;
      bytes_q  <= '0;
      blocks_q <= '0;
    end else if (wr_len) begin
      len_q   <= wval_p1;
      bytes_q <= wval_p1;
    end else if (wr_cnt) begin
      nblk_q   <= wval_p1;
      blocks_q <= wval_p1;
      bytes_q  <= len_q;
    end else if (step) begin
      if (last_byte) begin
        bytes_q  <= len_q;
        blocks_q <= (blocks_q == ONE) ? nblk_q : blocks_q - ONE;
      end else begin
        bytes_q <= bytes_q - ONE;
      end
    end
  end
endmodule

// File: rtl/xfer_seq_pack.sv
module xfer_seq_pack
  import xfer_seq_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last_byte,
  output logic              half_q,
  output logic              push_q,
  output logic [WORD_W-1:0] word_q
);
  logic [BYTE_W-1:0] low_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      half_q <= 1'b0;
      push_q <= 1'b0;
      low_q  <= '0;
      word_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (take) begin
        if (!half_q) begin
          if (last_byte) begin
            word_q <= {{BYTE_W{1'b0}}, byte_in};
            push_q <= 1'b1;
          end else begin
            low_q  <= byte_in;
            half_q <= 1'b1;
          end
        end else begin
          word_q <= {byte_in, low_q};
          push_q <= 1'b1;
          half_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/xfer_seq_unpack.sv
module xfer_seq_unpack (
  input  logic clk,
  input  logic clr,
  input  logic take,
  input  logic last_byte,
  output logic hi_q,
  output logic pop_q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      hi_q  <= 1'b0;
      pop_q <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (take) begin
        if (!hi_q && !last_byte) begin
          hi_q <= 1'b1;
        end else begin
          hi_q  <= 1'b0;
          pop_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int LVL_W = 6,
  parameter int AF_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_en,
  input  logic                    soft_rst,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [LEN_W-1:0]        cfg_wdata,
  input  logic                    xfer_start,
  input  logic                    xfer_rx,
  input  logic [AF_W-1:0]         af_level,
  output logic [LEN_W:0]          bytes_left,
  output logic [LEN_W:0]          blocks_left,
  output logic                    xfer_active,
  output logic                    xfer_done,
  input  logic                    card_rx_valid,
  input  logic [7:0]              card_rx_data,
  output logic                    card_rx_ready,
  output logic                    card_tx_valid,
  output logic [7:0]              card_tx_data,
  input  logic                    card_tx_ready,
  input  logic [LVL_W-1:0]        fifo_level,
  input  logic [15:0]             fifo_rdata,
  output logic                    fifo_wr_en,
  output logic [15:0]             fifo_wdata,
  output logic                    fifo_rd_en
);
  localparam int CNT_W = LEN_W + 1;

  logic abort, cfg_ok, wr_len, wr_cnt, start_ok;
  logic active_q, rx_q, done_q;
  logic rx_take, tx_take, step, last_byte, xfer_end;
  logic rx_half, tx_hi, room;
  logic [CNT_W-1:0] bytes_q, blocks_q;

  assign abort    = !ctl_en || soft_rst;
  assign cfg_ok   = cfg_we && !abort;
  assign wr_len   = cfg_ok && (cfg_sel_e'(cfg_sel) == SEL_LEN);
  assign wr_cnt   = cfg_ok && (cfg_sel_e'(cfg_sel) == SEL_CNT);
  assign start_ok = xfer_start && !abort && !active_q &&
                    (bytes_q != '0) && (blocks_q != '0);

  // Receive side: a new word needs room and no push still in flight.
  assign room          = !fifo_wr_en && (fifo_level <= LVL_W'(af_level));
  assign card_rx_ready = active_q && rx_q && (rx_half || room);
  assign rx_take       = card_rx_ready && card_rx_valid;

  // Transmit side: the head word is valid once no pop is in flight.
  assign card_tx_valid = active_q && !rx_q && !fifo_rd_en && (fifo_level != '0);
  assign card_tx_data  = tx_hi ? fifo_rdata[WORD_W-1:BYTE_W] : fifo_rdata[BYTE_W-1:0];
  assign tx_take       = card_tx_valid && card_tx_ready;

  assign step = rx_take || tx_take;

  xfer_seq_count #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .wr_len    (wr_len),
    .wr_cnt    (wr_cnt),
    .wval      (cfg_wdata),
    .step      (step),
    .bytes_q   (bytes_q),
    .blocks_q  (blocks_q),
    .last_byte (last_byte),
    .xfer_end  (xfer_end)
  );

  xfer_seq_pack u_pack (
    .clk       (clk),
    .clr       (rst || abort || start_ok),
    .take      (rx_take),
    .byte_in   (card_rx_data),
    .last_byte (last_byte),
    .half_q    (rx_half),
    .push_q    (fifo_wr_en),
    .word_q    (fifo_wdata)
  );

  xfer_seq_unpack u_unpack (
    .clk       (clk),
    .clr       (rst || abort || start_ok),
    .take      (tx_take),
    .last_byte (last_byte),
    .hi_q      (tx_hi),
    .pop_q     (fifo_rd_en)
  );

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active_q <= 1'b0;
      rx_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= xfer_end;
      if (start_ok) begin
        active_q <= 1'b1;
        rx_q     <= xfer_rx;
      end else if (xfer_end) begin
        active_q <= 1'b0;
      end
    end
  end

  assign bytes_left  = bytes_q;
  assign blocks_left = blocks_q;
  assign xfer_active = active_q;
  assign xfer_done   = done_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int LEN_W = 11,
  parameter int LVL_W = 6,
  parameter int AF_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_en,
  input logic             soft_rst,
  input logic             cfg_we,
  input logic [AF_W-1:0]  af_level,
  input logic [LEN_W:0]   bytes_left,
  input logic [LEN_W:0]   blocks_left,
  input logic             xfer_active,
  input logic             xfer_done,
  input logic             card_rx_valid,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic             card_tx_ready,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_wr_en,
  input logic             fifo_rd_en,
  input logic             rx_half
);
  p_no_back2back_push_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |=> !fifo_wr_en);

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_en |-> (fifo_level != '0));

  p_rx_room_r5: assert property (@(posedge clk) disable iff (rst)
    (card_rx_ready && !rx_half) |-> (fifo_level <= LVL_W'(af_level)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> !xfer_active);

  p_abort_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en || soft_rst) |=> (bytes_left == '0 && blocks_left == '0 && !xfer_active));

  p_one_dir_r8: assert property (@(posedge clk) disable iff (rst)
    !(card_rx_ready && card_tx_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (xfer_active && ctl_en && !soft_rst && !cfg_we &&
     !(card_rx_ready && card_rx_valid) && !(card_tx_valid && card_tx_ready))
    |=> $stable(bytes_left));
endmodule

bind xfer_seq xfer_seq_chk #(.LEN_W(LEN_W), .LVL_W(LVL_W), .AF_W(AF_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ctl_en        (ctl_en),
  .soft_rst      (soft_rst),
  .cfg_we        (cfg_we),
  .af_level      (af_level),
  .bytes_left    (bytes_left),
  .blocks_left   (blocks_left),
  .xfer_active   (xfer_active),
  .xfer_done     (xfer_done),
  .card_rx_valid (card_rx_valid),
  .card_rx_ready (card_rx_ready),
  .card_tx_valid (card_tx_valid),
  .card_tx_ready (card_tx_ready),
  .fifo_level    (fifo_level),
  .fifo_wr_en    (fifo_wr_en),
  .fifo_rd_en    (fifo_rd_en),
  .rx_half       (rx_half)
);

// File: tb/xfer_seq_tb_top.sv
`timescale 1ns/1ps
module xfer_seq_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, ctl_en = 1'b1, soft_rst = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic        xfer_start = 1'b0, xfer_rx = 1'b0;
  logic [4:0]  af_level = 5'd31;
  logic [11:0] bytes_left, blocks_left;
  logic        xfer_active, xfer_done;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic [7:0]  card_rx_data, card_tx_data;
  logic [5:0]  fifo_level;
  logic [15:0] fifo_rdata, fifo_wdata;
  logic        fifo_wr_en, fifo_rd_en;

  // bench-side controls
  logic        rx_gap = 1'b0, tx_gap = 1'b0, tx_hold = 1'b0;
  logic        tb_push = 1'b0, tb_drain = 1'b0, tb_flush = 1'b0;
  logic [15:0] tb_push_data = '0;

  // card and FIFO models
  logic [15:0] fm [0:31];
  logic [4:0]  wp = '0, rp = '0;
  logic [5:0]  fcnt = '0;
  logic [7:0]  rx_seq = 8'd1;
  logic [31:0] cyc = '0;
  logic [15:0] rx_log [0:255];
  logic [7:0]  tx_log [0:255];
  int          rx_n = 0, tx_n = 0;
  logic        m_push, m_pop;

  assign m_push        = fifo_wr_en || tb_push;
  assign m_pop         = fifo_rd_en || (tb_drain && fcnt != 0);
  assign fifo_level    = fcnt;
  assign fifo_rdata    = fm[rp];
  assign card_rx_data  = rx_seq;
  assign card_rx_valid = rx_gap ? cyc[0] : 1'b1;
  assign card_tx_ready = tx_hold ? 1'b0 : (tx_gap ? cyc[1] : 1'b1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (card_rx_ready && card_rx_valid) rx_seq <= rx_seq + 8'd1;
    if (card_tx_valid && card_tx_ready) begin
      tx_log[tx_n[7:0]] <= card_tx_data;
      tx_n <= tx_n + 1;
    end
    if (fifo_wr_en) begin
      rx_log[rx_n[7:0]] <= fifo_wdata;
      rx_n <= rx_n + 1;
    end
    if (rst || tb_flush) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (m_push) begin
        fm[wp] <= fifo_wr_en ? fifo_wdata : tb_push_data;
        wp <= wp + 5'd1;
      end
      if (m_pop) rp <= rp + 5'd1;
      fcnt <= fcnt + (m_push ? 6'd1 : 6'd0) - (m_pop ? 6'd1 : 6'd0);
    end
  end

  xfer_seq dut_i (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xfer_start(xfer_start), .xfer_rx(xfer_rx), .af_level(af_level),
    .bytes_left(bytes_left), .blocks_left(blocks_left),
    .xfer_active(xfer_active), .xfer_done(xfer_done),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
    .fifo_level(fifo_level), .fifo_rdata(fifo_rdata),
    .fifo_wr_en(fifo_wr_en), .fifo_wdata(fifo_wdata), .fifo_rd_en(fifo_rd_en)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic sel, input logic [10:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic start(input logic dir);
    @(negedge clk); xfer_start = 1'b1; xfer_rx = dir;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); tb_flush = 1'b1;
    @(negedge clk); tb_flush = 1'b0;
  endtask

  task automatic preload(input int nw);
    for (int j = 0; j < nw; j++) begin
      @(negedge clk); tb_push = 1'b1;
      tb_push_data = {8'(2*j+1) ^ 8'h55, 8'(2*j)};
    end
    @(negedge clk); tb_push = 1'b0;
  endtask

  task automatic pulse_disable();
    @(negedge clk); ctl_en = 1'b0;
    @(negedge clk); ctl_en = 1'b1;
  endtask

  // [31] rx dir, [30] gaps, [29:19] length-1, [18:8] count-1, [4:0] almost-full
  localparam logic [31:0] VEC [6] = '{
    {1'b1, 1'b0, 11'd3, 11'd1, 3'd0, 5'd31},
    {1'b1, 1'b1, 11'd2, 11'd2, 3'd0, 5'd31},
    {1'b1, 1'b0, 11'd0, 11'd1, 3'd0, 5'd4},
    {1'b0, 1'b0, 11'd3, 11'd1, 3'd0, 5'd0},
    {1'b0, 1'b1, 11'd4, 11'd1, 3'd0, 5'd0},
    {1'b0, 1'b0, 11'd0, 11'd2, 3'd0, 5'd0}
  };

  task automatic run_vec(input logic [31:0] v);
    int L, N, base, r0, t0, nexp, bad, k, j, w, to;
    bit seen;
    logic [15:0] ew;
    logic [7:0]  eb;
    L = int'(v[29:19]) + 1;
    N = int'(v[18:8]) + 1;
    flush();
    af_level = v[4:0];
    cfg_write(1'b0, v[29:19]);
    cfg_write(1'b1, v[18:8]);
    bad = 0; nexp = 0; seen = 1'b0;
    if (v[31]) begin
      rx_gap = v[30]; tb_drain = 1'b1;
      base = int'(rx_seq); r0 = rx_n;
      start(1'b1);
    end else begin
      tx_gap = v[30];
      preload(N * ((L + 1) / 2));
      t0 = tx_n;
      start(1'b0);
    end
    to = 0;
    while (!seen && to < 3000) begin
      if (xfer_done) seen = 1'b1;
      if (!seen) begin @(negedge clk); to++; end
    end
    tick(3);
    check(seen, "R10 done pulse", int'(seen), 1);
    check(!xfer_active, "R10 idle after done", int'(xfer_active), 0);
    check(bytes_left == 12'(L) && blocks_left == 12'(N), "R10/R11 counters reloaded",
          int'(blocks_left), N);
    if (v[31]) begin
      k = base;
      for (int b = 0; b < N; b++)
        for (int i = 0; i < L; i += 2) begin
          if (i + 1 < L) begin ew = {8'(k + 1), 8'(k)}; k += 2; end
          else begin ew = {8'h00, 8'(k)}; k += 1; end
          if (rx_log[(r0 + nexp) % 256] !== ew) bad++;
          nexp++;
        end
      check(rx_n - r0 == nexp, "R4 word count", rx_n - r0, nexp);
      check(bad == 0, "R4 packing", bad, 0);
    end else begin
      j = 0; w = 0;
      for (int b = 0; b < N; b++)
        for (int i = 0; i < L; i += 2) begin
          eb = 8'(2*j);
          if (tx_log[(t0 + w) % 256] !== eb) bad++;
          w++;
          if (i + 1 < L) begin
            eb = 8'(2*j+1) ^ 8'h55;
            if (tx_log[(t0 + w) % 256] !== eb) bad++;
            w++;
          end
          j++;
        end
      check(tx_n - t0 == w, "R6 byte count", tx_n - t0, w);
      check(bad == 0, "R6 byte order", bad, 0);
    end
    tb_drain = 1'b0; rx_gap = 1'b0; tx_gap = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(bytes_left == 0 && blocks_left == 0, "R1 counters zero", int'(bytes_left), 0);
    check(!xfer_active && !card_rx_ready && !card_tx_valid && !fifo_wr_en &&
          !fifo_rd_en && !xfer_done, "R1 outputs idle", int'(xfer_active), 0);

    // R13 start with zero counters is ignored
    start(1'b1);
    check(!xfer_active, "R13 start ignored on zero count", int'(xfer_active), 0);

    // R2 length write
    cfg_write(1'b0, 11'd5);
    check(bytes_left == 12'd6, "R2 length load", int'(bytes_left), 6);
    cfg_write(1'b0, 11'h7FF);
    check(bytes_left == 12'd2048, "R2 max length", int'(bytes_left), 2048);

    // R12 soft reset clears
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check(bytes_left == 0 && blocks_left == 0, "R12 soft reset clears", int'(bytes_left), 0);

    // vector table
    foreach (VEC[i]) run_vec(VEC[i]);

    // R9 block boundary: 2-byte blocks, 3 blocks, park at almost-full 0
    flush(); af_level = 5'd0;
    cfg_write(1'b0, 11'd1); cfg_write(1'b1, 11'd2);
    start(1'b1);
    tick(10);
    check(blocks_left == 12'd2, "R9 block decrement", int'(blocks_left), 2);
    check(bytes_left == 12'd2, "R9 byte reload", int'(bytes_left), 2);
    check(!card_rx_ready && fifo_level == 6'd1, "R5 parked above level", int'(fifo_level), 1);
    // R13 restart while active is ignored
    start(1'b0);
    check(xfer_active && card_tx_valid == 1'b0, "R13 start ignored when active",
          int'(card_tx_valid), 0);
    pulse_disable();

    // R11 live counter, then R3 reload from length mid-block
    flush(); af_level = 5'd0;
    cfg_write(1'b0, 11'd7); cfg_write(1'b1, 11'd0);
    start(1'b1);
    tick(10);
    check(bytes_left == 12'd6, "R11 live byte count", int'(bytes_left), 6);
    cfg_write(1'b1, 11'd3);
    check(bytes_left == 12'd8 && blocks_left == 12'd4, "R3 count write reloads",
          int'(bytes_left), 8);
    // R12 disable aborts and ignores writes
    @(negedge clk); ctl_en = 1'b0;
    @(negedge clk);
    check(!xfer_active && bytes_left == 0 && blocks_left == 0, "R12 disable aborts",
          int'(bytes_left), 0);
    cfg_write(1'b0, 11'd9);
    check(bytes_left == 0, "R12 write ignored while disabled", int'(bytes_left), 0);
    @(negedge clk); ctl_en = 1'b1;

    // R5 pause at almost-full 2 with no drain
    flush(); af_level = 5'd2;
    cfg_write(1'b0, 11'd63); cfg_write(1'b1, 11'd0);
    start(1'b1);
    tick(40);
    check(fifo_level == 6'd3 && !card_rx_ready, "R5 pause level", int'(fifo_level), 3);
    check(bytes_left == 12'd58, "R5 bytes moved before pause", int'(bytes_left), 58);
    pulse_disable();

    // R7 empty-FIFO stall, R8 ready respected
    flush();
    cfg_write(1'b0, 11'd1); cfg_write(1'b1, 11'd0);
    start(1'b0);
    tick(4);
    check(!card_tx_valid && bytes_left == 12'd2, "R7 stall on empty", int'(bytes_left), 2);
    tx_hold = 1'b1;
    begin
      int t0;
      t0 = tx_n;
      preload(1);
      tick(5);
      check(bytes_left == 12'd2 && tx_n == t0, "R8 no handshake no move",
            int'(bytes_left), 2);
      tx_hold = 1'b0;
      tick(6);
      check(tx_n - t0 == 2 && tx_log[t0 % 256] == 8'h00 && tx_log[(t0+1) % 256] == 8'h54,
            "R6 low then high", tx_n - t0, 2);
      check(!xfer_active && fifo_level == 0, "R10 finished and popped",
            int'(fifo_level), 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule